// File: doc/BRIEF.md
# DDR SDRAM Command Spacing Monitor

This block sits beside the command path of a memory controller and watches every command sent to a multi-bank DDR SDRAM device. It compares the spacing between related commands against the device's minimum timing limits and reports any command that arrives too early. It generates no commands and never stalls the stream. Its only outputs are one pulse bit per timing rule and a latched code that names the first rule that was broken.

The nanosecond limits are parameters. The limits are converted to clock counts at elaboration: each one is divided by the clock period, given in picoseconds, and rounded up. The write-with-auto-precharge recovery limit is the sum of two terms, each rounded up on its own. Same-bank rules are tracked by a set of down-counters for each bank. The cross-bank activate rule and the write-to-read turnaround rule are tracked by counters shared by all banks.

Commands are encoded on a 3-bit input: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 auto-refresh, 6 read with auto-precharge, 7 write with auto-precharge. Auto-refresh acts on every bank. All other commands act on the bank given on the bank input.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: An activate, or an auto-refresh, that reaches bank b fewer than ceil(TRC_PS/CLK_PS) cycles after an earlier activate or auto-refresh reached b sets viol_o bit 0.
- R2: A read, write, read-with-auto-precharge or write-with-auto-precharge to bank b fewer than ceil(TRCD_PS/CLK_PS) cycles after an activate to b sets viol_o bit 1.
- R3: Any non-idle command reaching bank b fewer than ceil(TRP_PS/CLK_PS) cycles after a precharge or a read-with-auto-precharge to b sets viol_o bit 2. Auto-refresh counts as reaching every bank.
- R4: An activate to a bank other than the one targeted by the most recent activate, fewer than ceil(TRRD_PS/CLK_PS) cycles after that activate, sets viol_o bit 3. An activate to the same bank never sets bit 3.
- R5: A precharge to bank b fewer than WR_DATA_CK + ceil(TWR_PS/CLK_PS) cycles after a write or write-with-auto-precharge to b sets viol_o bit 4.
- R6: An activate or auto-refresh reaching bank b fewer than WR_DATA_CK + ceil(TWR_PS/CLK_PS) + ceil(TRP_PS/CLK_PS) cycles after a write-with-auto-precharge to b sets viol_o bit 5. The two terms are rounded separately.
- R7: A read or read-with-auto-precharge to any bank fewer than WR_DATA_CK + TWTR_CK cycles after a write of either kind to any bank sets viol_o bit 6.
- R8: A violation bit is a registered one-cycle pulse, high in the cycle after the clock edge that sampled the offending command. A spacing equal to or greater than the limit is never flagged. An offending command still restarts the counters it triggers.
- R9: The idle command never raises a violation. A command on one bank never raises a same-bank violation (R1, R2, R3, R5, R6) for a different bank.
- R10: err_code_o latches (index of the lowest set violation bit) + 1 on the first violating command, keeps that value through later violations, and returns to 0, together with viol_o, under synchronous reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one command is sampled per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code (0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 auto-refresh, 6 read-ap, 7 write-ap) |
| bank_i | input | $clog2(NBANK) | Bank address of the command |
| viol_o | output | 7 | Per-rule violation pulses, bits 0..6 as in R1..R7 |
| err_code_o | output | 4 | Sticky code of the first violated rule, 0 when none |

## Verification
On every cycle, the assertions check the following:
- Idle commands and unrelated command types never raise a rule bit.
- Back-to-back activates to one bank flag the row-cycle rule but not the cross-bank rule.
- The error code is set on the first violation and never changes afterwards.

The exact cycle counts are shown only by the bench's spacing sweeps. These include the boundary where a spacing equal to the limit is accepted, and the auto-precharge recovery limit formed from two separately rounded terms. The bench also covers bank isolation and the priority among violations that arrive together.

// File: rtl/ddr_tmon_pkg.sv
package ddr_tmon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_RDA = 3'd6,
    CMD_WRA = 3'd7
  } cmd_e;

  localparam int NRULE   = 7;
  localparam int RI_RC   = 0;
  localparam int RI_RCD  = 1;
  localparam int RI_RP   = 2;
  localparam int RI_RRD  = 3;
  localparam int RI_WR   = 4;
  localparam int RI_DAL  = 5;
  localparam int RI_WTR  = 6;

  // ceiling division of a picosecond limit by the clock period
  function automatic int ps2ck(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // code of the lowest-index set rule bit, 0 when none
  function automatic logic [3:0] first_code(input logic [NRULE-1:0] v);
    logic [3:0] c;
    c = 4'd0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (v[i]) c = 4'(i + 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/ddr_tmon_cnt.sv
module ddr_tmon_cnt #(
  parameter int W     = 4,
  parameter int LIMIT = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  output logic busy_o
);
  localparam int LV = (LIMIT > 0) ? LIMIT - 1 : 0;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= W'(LV);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ddr_tmon_bank.sv
module ddr_tmon_bank
  import ddr_tmon_pkg::*;
#(
  parameter int W     = 4,
  parameter int L_RC  = 1,
  parameter int L_RCD = 1,
  parameter int L_RP  = 1,
  parameter int L_WR  = 1,
  parameter int L_DAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  cmd_e             cmd_i,
  input  logic             sel_i,
  output logic [NRULE-1:0] viol_o
);
  logic act, rdx, wrx, pre, rfr, rda, wra, any;
  logic rc_b, rcd_b, rp_b, wr_b, dal_b;

  always_comb begin
    act = sel_i && (cmd_i == CMD_ACT);
    rdx = sel_i && ((cmd_i == CMD_RD) || (cmd_i == CMD_RDA));
    wrx = sel_i && ((cmd_i == CMD_WR) || (cmd_i == CMD_WRA));
    pre = sel_i && (cmd_i == CMD_PRE);
    rda = sel_i && (cmd_i == CMD_RDA);
    wra = sel_i && (cmd_i == CMD_WRA);
    rfr = (cmd_i == CMD_REF);
    any = (sel_i && (cmd_i != CMD_NOP)) || rfr;
  end

  ddr_tmon_cnt #(.W(W), .LIMIT(L_RC)) u_rc (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(act || rfr), .busy_o(rc_b));
  ddr_tmon_cnt #(.W(W), .LIMIT(L_RCD)) u_rcd (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(act), .busy_o(rcd_b));
  ddr_tmon_cnt #(.W(W), .LIMIT(L_RP)) u_rp (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(pre || rda), .busy_o(rp_b));
  ddr_tmon_cnt #(.W(W), .LIMIT(L_WR)) u_wr (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(wrx), .busy_o(wr_b));
  ddr_tmon_cnt #(.W(W), .LIMIT(L_DAL)) u_dal (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(wra), .busy_o(dal_b));

  always_comb begin
    viol_o         = '0;
    viol_o[RI_RC]  = (act || rfr) && rc_b;
    viol_o[RI_RCD] = (rdx || wrx) && rcd_b;
    viol_o[RI_RP]  = any && rp_b;
    viol_o[RI_WR]  = pre && wr_b;
    viol_o[RI_DAL] = (act || rfr) && dal_b;
  end
endmodule

// File: rtl/ddr_tmon_global.sv
module ddr_tmon_global
  import ddr_tmon_pkg::*;
#(
  parameter int W     = 4,
  parameter int BW    = 2,
  parameter int L_RRD = 1,
  parameter int L_WTR = 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  cmd_e          cmd_i,
  input  logic [BW-1:0] bank_i,
  output logic          rrd_viol_o,
  output logic          wtr_viol_o
);
  logic          act, rdx, wrx;
  logic          rrd_b, wtr_b;
  logic [BW-1:0] last_act_q;

  always_comb begin
    act = (cmd_i == CMD_ACT);
    rdx = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA);
    wrx = (cmd_i == CMD_WR) || (cmd_i == CMD_WRA);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      last_act_q <= '0;
    end else if (act) begin
      last_act_q <= bank_i;
    end
  end

  ddr_tmon_cnt #(.W(W), .LIMIT(L_RRD)) u_rrd (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(act), .busy_o(rrd_b));
  ddr_tmon_cnt #(.W(W), .LIMIT(L_WTR)) u_wtr (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(wrx), .busy_o(wtr_b));

  assign rrd_viol_o = act && rrd_b && (bank_i != last_act_q);
  assign wtr_viol_o = rdx && wtr_b;
endmodule

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon
  import ddr_tmon_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int CLK_PS     = 7500,
  parameter int TRC_PS     = 65000,
  parameter int TRCD_PS    = 20000,
  parameter int TRP_PS     = 20000,
  parameter int TRRD_PS    = 15000,
  parameter int TWR_PS     = 15000,
  parameter int TWTR_CK    = 1,
  parameter int WR_DATA_CK = 2,
  localparam int BW        = $clog2(NBANK)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [2:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  output logic [6:0]    viol_o,
  output logic [3:0]    err_code_o
);
  localparam int L_RC  = ps2ck(TRC_PS, CLK_PS);
  localparam int L_RCD = ps2ck(TRCD_PS, CLK_PS);
  localparam int L_RP  = ps2ck(TRP_PS, CLK_PS);
  localparam int L_RRD = ps2ck(TRRD_PS, CLK_PS);
  localparam int L_TWR = ps2ck(TWR_PS, CLK_PS);
  localparam int L_WR  = WR_DATA_CK + L_TWR;
  localparam int L_DAL = WR_DATA_CK + L_TWR + L_RP;
  localparam int L_WTR = WR_DATA_CK + TWTR_CK;
  localparam int L_MAX = imax(imax(imax(L_RC, L_RCD), imax(L_RP, L_RRD)),
                              imax(imax(L_WR, L_DAL), L_WTR));
  localparam int CW    = $clog2(L_MAX + 1);

  cmd_e             cmd;
  logic [NRULE-1:0] bank_viol [NBANK];
  logic [NRULE-1:0] viol_d;
  logic             rrd_v, wtr_v;

  assign cmd = cmd_e'(cmd_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr_tmon_bank #(
      .W(CW), .L_RC(L_RC), .L_RCD(L_RCD), .L_RP(L_RP),
      .L_WR(L_WR), .L_DAL(L_DAL)
    ) u_bank (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .cmd_i (cmd),
      .sel_i (bank_i == BW'(b)),
      .viol_o(bank_viol[b])
    );
  end

  ddr_tmon_global #(
    .W(CW), .BW(BW), .L_RRD(L_RRD), .L_WTR(L_WTR)
  ) u_global (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cmd_i     (cmd),
    .bank_i    (bank_i),
    .rrd_viol_o(rrd_v),
    .wtr_viol_o(wtr_v)
  );

  always_comb begin
    viol_d = '0;
    for (int b = 0; b < NBANK; b++) begin
      viol_d = viol_d | bank_viol[b];
    end
    viol_d[RI_RRD] = rrd_v;
    viol_d[RI_WTR] = wtr_v;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      viol_o     <= '0;
      err_code_o <= '0;
    end else begin
      viol_o <= viol_d;
      if ((err_code_o == 4'd0) && (viol_d != '0)) begin
        err_code_o <= first_code(viol_d);
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_timing_mon_chk.sv
module ddr_cmd_timing_mon_chk #(
  parameter int BW     = 2,
  parameter int CLK_PS = 7500,
  parameter int TRC_PS = 65000
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic [2:0]    cmd_i,
  input logic [BW-1:0] bank_i,
  input logic [6:0]    viol_o,
  input logic [3:0]    err_code_o
);
  localparam bit RC_GT1 = ((TRC_PS + CLK_PS - 1) / CLK_PS) > 1;

  // R9: idle never flags anything
  a_r9_nop_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == 3'd0) |=> (viol_o == 7'd0));

  // R10: once set, the error code holds
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_code_o != 4'd0) |=> $stable(err_code_o));

  // R10: a first violation always leaves a code behind
  a_r10_err_on_first: assert property (@(posedge clk_i) disable iff (rst_i)
    (err_code_o == 4'd0) |=> ((viol_o == 7'd0) || (err_code_o != 4'd0)));

  // R2: only column commands flag the activate-to-column rule
  a_r2_rcd_source: assert property (@(posedge clk_i) disable iff (rst_i)
    !((cmd_i == 3'd2) || (cmd_i == 3'd3) || (cmd_i == 3'd6) || (cmd_i == 3'd7))
      |=> !viol_o[1]);

  // R5: only precharge flags write recovery
  a_r5_wr_source: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i != 3'd4) |=> !viol_o[4]);

  // R7: only reads flag the write-to-read turnaround
  a_r7_wtr_source: assert property (@(posedge clk_i) disable iff (rst_i)
    !((cmd_i == 3'd2) || (cmd_i == 3'd6)) |=> !viol_o[6]);

  // R4: back-to-back activates on one bank are never a cross-bank violation
  a_r4_same_bank_no_rrd: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == 3'd1) ##1 ((cmd_i == 3'd1) && (bank_i == $past(bank_i)))
      |=> !viol_o[3]);

  // R1: back-to-back activates on one bank break the row-cycle rule
  a_r1_b2b_act: assert property (@(posedge clk_i) disable iff (rst_i)
    (RC_GT1 && (cmd_i == 3'd1)) ##1 ((cmd_i == 3'd1) && (bank_i == $past(bank_i)))
      |=> viol_o[0]);

  // R10: code range is limited to the rule count
  always_ff @(posedge clk_i) begin
    if (!rst_i) begin
      a_r10_code_range: assert (err_code_o <= 4'd7);
    end
  end
endmodule

bind ddr_cmd_timing_mon ddr_cmd_timing_mon_chk #(
  .BW($clog2(NBANK)), .CLK_PS(CLK_PS), .TRC_PS(TRC_PS)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cmd_i     (cmd_i),
  .bank_i    (bank_i),
  .viol_o    (viol_o),
  .err_code_o(err_code_o)
);

// File: tb/ddr_cmd_timing_mon_tb.sv
module ddr_cmd_timing_mon_tb;
  localparam int CLK_PS = 6000;
  localparam int WRD    = 2;
  localparam int L_RC   = (65000 + CLK_PS - 1) / CLK_PS;
  localparam int L_RCD  = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int L_RP   = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int L_RRD  = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int L_TWR  = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int L_WR   = WRD + L_TWR;
  localparam int L_DAL  = WRD + L_TWR + L_RP;
  localparam int L_WTR  = WRD + 1;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, RDA = 3'd6, WRA = 3'd7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic [6:0] viol;
  logic [3:0] err;
  logic [6:0] lastv;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ddr_cmd_timing_mon #(.NBANK(4), .CLK_PS(CLK_PS), .WR_DATA_CK(WRD)) u_dut (
    .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .bank_i(bank),
    .viol_o(viol), .err_code_o(err));

  task automatic cyc(input logic [2:0] c, input logic [1:0] b);
    @(negedge clk);
    lastv = viol;
    cmd   = c;
    bank  = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(NOP, 2'd0);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; cmd = NOP; bank = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [6:0] bt(input int idx, input bit on);
    return on ? 7'(1 << idx) : 7'd0;
  endfunction

  initial begin
    reset_dut();
    @(negedge clk);
    chk("R10 reset viol", viol, 7'd0);
    chk("R10 reset code", {3'd0, err}, 7'd0);

    // R1: activate to activate, same bank, all banks
    for (int b = 0; b < 4; b++) begin
      for (int d = 1; d <= L_RC + 1; d++) begin
        reset_dut();
        cyc(ACT, 2'(b)); idle(d - 1); cyc(ACT, 2'(b)); cyc(NOP, 2'd0);
        chk("R1 act-act", lastv, bt(0, d < L_RC));
        chk("R10 code", {3'd0, err}, (d < L_RC) ? 7'd1 : 7'd0);
      end
    end
    // R1: activate to auto-refresh
    for (int d = 1; d <= L_RC + 1; d++) begin
      reset_dut();
      cyc(ACT, 2'd2); idle(d - 1); cyc(REF, 2'd0); cyc(NOP, 2'd0);
      chk("R1 act-ref", lastv, bt(0, d < L_RC));
    end
    // R2: activate to read and write
    for (int k = 0; k < 2; k++) begin
      for (int d = 1; d <= L_RCD + 1; d++) begin
        reset_dut();
        cyc(ACT, 2'd1); idle(d - 1); cyc(k == 0 ? RD : WR, 2'd1); cyc(NOP, 2'd0);
        chk("R2 act-col", lastv, bt(1, d < L_RCD));
      end
    end
    // R3: precharge to activate
    for (int d = 1; d <= L_RP + 1; d++) begin
      reset_dut();
      cyc(PRE, 2'd3); idle(d - 1); cyc(ACT, 2'd3); cyc(NOP, 2'd0);
      chk("R3 pre-act", lastv, bt(2, d < L_RP));
    end
    // R3: read-ap acts as precharge; R1 also checked on the same activate
    for (int d = 1; d <= L_RC - L_RCD + 1; d++) begin
      reset_dut();
      cyc(ACT, 2'd0); idle(L_RCD - 1); cyc(RDA, 2'd0); idle(d - 1);
      cyc(ACT, 2'd0); cyc(NOP, 2'd0);
      chk("R3 rda-act", lastv, bt(2, d < L_RP) | bt(0, L_RCD + d < L_RC));
    end
    // R4: cross-bank activate spacing
    for (int b = 0; b < 4; b++) begin
      for (int d = 1; d <= L_RRD + 1; d++) begin
        reset_dut();
        cyc(ACT, 2'(b)); idle(d - 1); cyc(ACT, 2'((b + 1) % 4)); cyc(NOP, 2'd0);
        chk("R4 rrd", lastv, bt(3, d < L_RRD));
      end
    end
    // R5: write / write-ap to precharge
    for (int k = 0; k < 2; k++) begin
      for (int d = 1; d <= L_WR + 1; d++) begin
        reset_dut();
        cyc(ACT, 2'd3); idle(L_RCD - 1); cyc(k == 0 ? WR : WRA, 2'd3); idle(d - 1);
        cyc(PRE, 2'd3); cyc(NOP, 2'd0);
        chk("R5 wr-pre", lastv, bt(4, d < L_WR));
      end
    end
    // R6: write-ap to activate; limit is a sum of separately rounded terms
    for (int d = 1; d <= L_DAL + 1; d++) begin
      reset_dut();
      cyc(ACT, 2'd1); idle(L_RCD - 1); cyc(WRA, 2'd1); idle(d - 1);
      cyc(ACT, 2'd1); cyc(NOP, 2'd0);
      chk("R6 wra-act", lastv, bt(5, d < L_DAL) | bt(0, L_RCD + d < L_RC));
    end
    // R7: write to read on another bank, plain and auto-precharge read
    for (int k = 0; k < 2; k++) begin
      for (int d = 1; d <= L_WTR + 1; d++) begin
        reset_dut();
        cyc(ACT, 2'd0); idle(L_RRD - 1); cyc(ACT, 2'd1); idle(L_RCD - 1);
        cyc(WR, 2'd0); idle(d - 1); cyc(k == 0 ? RD : RDA, 2'd1); cyc(NOP, 2'd0);
        chk("R7 wtr", lastv, bt(6, d < L_WTR));
      end
    end
    // R9: bank isolation and idle
    reset_dut();
    cyc(PRE, 2'd0); cyc(ACT, 2'd1); cyc(NOP, 2'd0);
    chk("R9 pre other bank", lastv, 7'd0);
    reset_dut();
    cyc(WR, 2'd2); cyc(PRE, 2'd3); cyc(NOP, 2'd0);
    chk("R9 wr other bank", lastv, 7'd0);
    reset_dut();
    cyc(WRA, 2'd0); cyc(ACT, 2'd2); cyc(NOP, 2'd0);
    chk("R9 wra other bank", lastv, 7'd0);
    cyc(NOP, 2'd0);
    chk("R9 nop", lastv, 7'd0);
    // R4: same bank activate is not a cross-bank violation
    reset_dut();
    cyc(ACT, 2'd2); cyc(ACT, 2'd2); cyc(NOP, 2'd0);
    chk("R4 same bank", lastv, bt(0, 1'b1));
    // R8: violating command still restarts its counter
    reset_dut();
    cyc(ACT, 2'd0); idle(L_RC - 2); cyc(ACT, 2'd0); idle(L_RC - 2);
    cyc(ACT, 2'd0); cyc(NOP, 2'd0);
    chk("R8 reload", lastv, bt(0, 1'b1));
    // R10: simultaneous rules pick the lowest, later violations keep the code
    reset_dut();
    cyc(REF, 2'd0); cyc(WRA, 2'd0); cyc(ACT, 2'd0); cyc(NOP, 2'd0);
    chk("R10 simultaneous viol", lastv, bt(0, 1'b1) | bt(5, 1'b1));
    chk("R10 simultaneous code", {3'd0, err}, 7'd1);
    reset_dut();
    cyc(PRE, 2'd2); cyc(ACT, 2'd2); cyc(NOP, 2'd0);
    chk("R10 first code", {3'd0, err}, 7'd3);
    cyc(ACT, 2'd0); cyc(ACT, 2'd0); cyc(NOP, 2'd0);
    chk("R10 later viol", lastv, bt(0, 1'b1));
    chk("R10 sticky", {3'd0, err}, 7'd3);
    reset_dut();
    @(negedge clk);
    chk("R10 reset clears", {3'd0, err}, 7'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule